// File: doc/BRIEF.md
# Vectored Interrupt Concentrator

This block gathers interrupt requests from twelve sources into a single prioritised request to a processor. Ten sources are hardware lines. One of them is a pushbutton abort switch whose live state can be read back. The other two are software sources that a register write raises. Each source owns one control byte. That byte holds a latched pending flag, an enable, a three-bit priority level and, for two sources, one extra field.

The block drives a three-bit level to the processor. This level is the highest priority found among the sources that are both pending and enabled, and it is forced to zero while the global enable is off. When the processor runs an acknowledge cycle at the level it was shown, the block answers one cycle later with an 8-bit vector. The vector is a programmable base plus the fixed index of the winning source. The serial source can instead hand vectoring to its own device. Pending flags survive the acknowledge, so software clears them by writing a one to the flag.

Register map on `bus_addr`: 0 to 11 are the source control bytes, indexed by source. The sources are 0 power fail, 1 bus error, 2 abort, 3 serial, 4 ethernet, 5 disk port, 6 disk DMA, 7 printer, 8 timer one, 9 timer two, 10 software one and 11 software two. Address 12 is general control, address 13 is the vector base, and all other addresses read zero.

Top module: `irq_concentrator`

## Requirements
- R1: After reset every control byte, general control and the vector base read 0x00, `cpu_level` is 0 and `ack_valid` is low.
- R2: In a control byte, bit 3 is the enable and bits 2:0 the level. Both are written and read back as written, and bit 7 reads the pending flag.
- R3: Hardware source i (0..9, line `hw_irq[i]`) becomes pending on the clock edge where the line is first seen high after being low. A line held high does not re-assert pending after it is cleared.
- R4: Writing a control byte with bit 7 set clears that source's pending flag. Writing it with bit 7 clear leaves the flag unchanged.
- R5: For sources 10 and 11, writing a control byte with bit 6 set makes the source pending.
- R6: `cpu_level` equals the highest level among sources that are pending and enabled. A source with level 0 or with its enable clear produces no request.
- R7: When several requesting sources share the highest level, the lowest index is the winner used for the vector.
- R8: Bit 4 of general control (address 12) is the global enable. While it is clear, `cpu_level` is 0.
- R9: An acknowledge (`iack_req` high) whose `iack_level` equals a nonzero `cpu_level` gives `ack_valid` high on the next cycle. `ack_vector` then equals the vector base (address 13) plus the winner's index, modulo 256, and the pending flag is not changed.
- R10: An acknowledge whose level differs from `cpu_level`, or arrives while `cpu_level` is 0, gives no response.
- R11: Serial source 3 has a vector-supply bit at bit 4. When the serial source wins an acknowledge with this bit clear, the response has `ack_ext` high and `ack_vector` 0x00. With the bit set, the normal vector is returned and `ack_ext` is low.
- R12: Abort source 2 shows the state of `hw_irq[2]`, as sampled on the previous clock edge, in bit 6 of its control byte.
- R13: A rising edge on a hardware line in the same cycle as a write that clears that source leaves the source pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| hw_irq | input | 10 | Hardware request lines for sources 0..9 |
| cpu_level | output | 3 | Request level to the processor, 0 = none |
| iack_req | input | 1 | Acknowledge cycle strobe |
| iack_level | input | 3 | Level being acknowledged |
| ack_valid | output | 1 | Acknowledge response, one cycle after the request |
| ack_vector | output | 8 | Vector returned with the response |
| ack_ext | output | 1 | Vector left to the serial device |

## Verification
A lost or stuck pending flag shows up in the same cycle, either in `cpu_level` or in bit 7 of the source's control byte. A wrong priority comparison shows up as a wrong level, and a broken tie rule or a wrong index shows up in the vector one cycle after the acknowledge. The bench keeps expected responses in a queue and checks every response the block produces. Any response that appears without an expected entry, or that carries the wrong vector or external flag, is caught on the cycle it appears.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_SRC    = 12;
    localparam int LVL_W      = 3;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 4;
    localparam int IDX_W      = $clog2(NUM_SRC);
    localparam int NUM_HW     = 10;
    localparam int ABORT_IDX  = 2;
    localparam int SERIAL_IDX = 3;
    localparam int GEN_ADDR   = NUM_SRC;
    localparam int VBASE_ADDR = NUM_SRC + 1;

    localparam int PEND_BIT   = 7;
    localparam int LIVE_BIT   = 6;
    localparam int SWSET_BIT  = 6;
    localparam int EXTV_BIT   = 4;
    localparam int EN_BIT     = 3;
    localparam int GEN_EN_BIT = 4;

    typedef enum logic [1:0] {
        SRC_PLAIN,
        SRC_SERIAL,
        SRC_ABORT,
        SRC_SOFT
    } src_kind_e;

    typedef struct packed {
        logic             pend;
        logic             live;
        logic             extv;
        logic             en;
        logic [LVL_W-1:0] lvl;
    } src_state_t;

    typedef struct packed {
        logic              valid;
        logic              ext;
        logic [DATA_W-1:0] vec;
    } ack_rsp_t;

    function automatic src_kind_e kind_of(input int idx);
        if (idx >= NUM_HW)      return SRC_SOFT;
        if (idx == SERIAL_IDX)  return SRC_SERIAL;
        if (idx == ABORT_IDX)   return SRC_ABORT;
        return SRC_PLAIN;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input src_state_t s);
        logic [DATA_W-1:0] b;
        b = '0;
        b[PEND_BIT]  = s.pend;
        b[LIVE_BIT]  = s.live;
        b[EXTV_BIT]  = s.extv;
        b[EN_BIT]    = s.en;
        b[LVL_W-1:0] = s.lvl;
        return b;
    endfunction

endpackage

// File: rtl/irqc_src_slot.sv
module irqc_src_slot
    import irqc_pkg::*;
#(
    parameter src_kind_e KIND = SRC_PLAIN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hw_rise,
    input  logic              hw_live,
    output src_state_t        st
);

    logic             pend_q;
    logic             en_q;
    logic [LVL_W-1:0] lvl_q;
    logic             extv_q;
    logic             set_ev;
    logic             clr_ev;
    logic             unused_bits;

    assign unused_bits = ^{hw_live, hw_rise, wdata[6:4]};

    generate
        if (KIND == SRC_SOFT) begin : g_soft
            assign set_ev = wr && wdata[SWSET_BIT];
        end else begin : g_hw
            assign set_ev = hw_rise;
        end
    endgenerate

    assign clr_ev = wr && wdata[PEND_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            en_q   <= 1'b0;
            lvl_q  <= '0;
        end else begin
            if (set_ev)
                pend_q <= 1'b1;
            else if (clr_ev)
                pend_q <= 1'b0;
            if (wr) begin
                en_q  <= wdata[EN_BIT];
                lvl_q <= wdata[LVL_W-1:0];
            end
        end
    end

    generate
        if (KIND == SRC_SERIAL) begin : g_extv
            always_ff @(posedge clk) begin
                if (rst)
                    extv_q <= 1'b0;
                else if (wr)
                    extv_q <= wdata[EXTV_BIT];
            end
        end else begin : g_no_extv
            assign extv_q = 1'b0;
        end
    endgenerate

    generate
        if (KIND == SRC_ABORT) begin : g_live
            assign st.live = hw_live;
        end else begin : g_no_live
            assign st.live = 1'b0;
        end
    endgenerate

    assign st.pend = pend_q;
    assign st.extv = extv_q;
    assign st.en   = en_q;
    assign st.lvl  = lvl_q;

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int N  = 12,
    parameter int LW = 3,
    parameter int IW = 4
) (
    input  logic [N-1:0]         req,
    input  logic [N-1:0][LW-1:0] lvl,
    output logic [LW-1:0]        win_lvl,
    output logic [IW-1:0]        win_idx
);

    always_comb begin
        win_lvl = '0;
        win_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (lvl[i] > win_lvl)) begin
                win_lvl = lvl[i];
                win_idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_ack_unit.sv
module irqc_ack_unit
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              iack_req,
    input  logic [LVL_W-1:0]  iack_level,
    input  logic [LVL_W-1:0]  cur_level,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic [DATA_W-1:0] vbase,
    input  logic              serial_extv,
    output ack_rsp_t          rsp
);

    logic     hit;
    logic     ext;
    ack_rsp_t rsp_d;

    assign hit = iack_req && (iack_level == cur_level) && (cur_level != '0);
    assign ext = (win_idx == IDX_W'(SERIAL_IDX)) && !serial_extv;

    always_comb begin
        rsp_d.valid = hit;
        rsp_d.ext   = hit && ext;
        rsp_d.vec   = '0;
        if (hit && !ext)
            rsp_d.vec = vbase + DATA_W'(win_idx);
    end

    always_ff @(posedge clk) begin
        if (rst)
            rsp <= '0;
        else
            rsp <= rsp_d;
    end

endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_HW-1:0] hw_irq,
    output logic [LVL_W-1:0]  cpu_level,
    input  logic              iack_req,
    input  logic [LVL_W-1:0]  iack_level,
    output logic              ack_valid,
    output logic [DATA_W-1:0] ack_vector,
    output logic              ack_ext
);

    logic [NUM_HW-1:0]             hw_q;
    logic [NUM_HW-1:0]             hw_rise;
    src_state_t [NUM_SRC-1:0]      st;
    logic [NUM_SRC-1:0]            req;
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
    logic [LVL_W-1:0]              win_lvl;
    logic [IDX_W-1:0]              win_idx;
    logic                          gen_en_q;
    logic [DATA_W-1:0]             vbase_q;
    ack_rsp_t                      rsp;

    always_ff @(posedge clk) begin
        if (rst)
            hw_q <= '0;
        else
            hw_q <= hw_irq;
    end

    assign hw_rise = hw_irq & ~hw_q;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
            localparam src_kind_e K = kind_of(gi);
            logic rise_i;
            logic live_i;
            if (gi < NUM_HW) begin : g_line
                assign rise_i = hw_rise[gi];
                assign live_i = hw_q[gi];
            end else begin : g_noline
                assign rise_i = 1'b0;
                assign live_i = 1'b0;
            end
            irqc_src_slot #(.KIND(K)) u_slot (
                .clk     (clk),
                .rst     (rst),
                .wr      (bus_we && (bus_addr == ADDR_W'(gi))),
                .wdata   (bus_wdata),
                .hw_rise (rise_i),
                .hw_live (live_i),
                .st      (st[gi])
            );
            assign req[gi] = st[gi].pend && st[gi].en;
            assign lvl[gi] = st[gi].lvl;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_en_q <= 1'b0;
            vbase_q  <= '0;
        end else if (bus_we) begin
            if (bus_addr == ADDR_W'(GEN_ADDR))
                gen_en_q <= bus_wdata[GEN_EN_BIT];
            if (bus_addr == ADDR_W'(VBASE_ADDR))
                vbase_q <= bus_wdata;
        end
    end

    irqc_arbiter #(.N(NUM_SRC), .LW(LVL_W), .IW(IDX_W)) u_arb (
        .req     (req),
        .lvl     (lvl),
        .win_lvl (win_lvl),
        .win_idx (win_idx)
    );

    assign cpu_level = gen_en_q ? win_lvl : '0;

    irqc_ack_unit u_ack (
        .clk         (clk),
        .rst         (rst),
        .iack_req    (iack_req),
        .iack_level  (iack_level),
        .cur_level   (cpu_level),
        .win_idx     (win_idx),
        .vbase       (vbase_q),
        .serial_extv (st[SERIAL_IDX].extv),
        .rsp         (rsp)
    );

    assign ack_valid  = rsp.valid;
    assign ack_vector = rsp.vec;
    assign ack_ext    = rsp.ext;

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_SRC; i++)
            if (bus_addr == ADDR_W'(i))
                bus_rdata = pack_ctrl(st[i]);
        if (bus_addr == ADDR_W'(GEN_ADDR))
            bus_rdata[GEN_EN_BIT] = gen_en_q;
        if (bus_addr == ADDR_W'(VBASE_ADDR))
            bus_rdata = vbase_q;
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [LVL_W-1:0]  cpu_level,
    input logic              iack_req,
    input logic [LVL_W-1:0]  iack_level,
    input logic              ack_valid,
    input logic [DATA_W-1:0] ack_vector,
    input logic              ack_ext
);

    logic accept;
    assign accept = iack_req && (iack_level == cpu_level) && (cpu_level != '0);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (cpu_level == '0) && !ack_valid);

    // R8
    glb_off_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(GEN_ADDR) && !bus_wdata[GEN_EN_BIT])
        |=> (cpu_level == '0));

    // R9
    ack_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> ack_valid);

    // R9
    keep_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !bus_we) |=> (cpu_level >= $past(cpu_level)));

    // R10
    no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !ack_valid);

    // R11
    ext_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_ext) |-> (ack_vector == '0));

endmodule

bind irq_concentrator irqc_checker u_irqc_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .cpu_level  (cpu_level),
    .iack_req   (iack_req),
    .iack_level (iack_level),
    .ack_valid  (ack_valid),
    .ack_vector (ack_vector),
    .ack_ext    (ack_ext)
);

// File: tb/tb_irq_concentrator.sv
module tb_irq_concentrator;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [9:0] hw_irq = '0;
    logic [2:0] cpu_level;
    logic       iack_req = 1'b0;
    logic [2:0] iack_level = '0;
    logic       ack_valid;
    logic [7:0] ack_vector;
    logic       ack_ext;

    typedef struct {
        logic [7:0] vec;
        logic       ext;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    always #4 clk = ~clk;

    irq_concentrator dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_irq(hw_irq),
        .cpu_level(cpu_level), .iack_req(iack_req), .iack_level(iack_level),
        .ack_valid(ack_valid), .ack_vector(ack_vector), .ack_ext(ack_ext)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] e, input string tag);
        bus_addr = a;
        #1;
        chk(bus_rdata == e, tag, bus_rdata, e);
    endtask

    task automatic lvl_chk(input logic [2:0] e, input string tag);
        chk(cpu_level == e, tag, cpu_level, e);
    endtask

    task automatic pulse(input int line);
        @(negedge clk);
        hw_irq[line] = 1'b1;
        @(negedge clk);
        hw_irq[line] = 1'b0;
    endtask

    // driver: issues an acknowledge and queues the expected response
    task automatic do_ack(input logic [2:0] l, input bit expect_rsp,
                          input logic [7:0] v, input logic x, input string tag);
        exp_t e;
        @(negedge clk);
        iack_req = 1'b1; iack_level = l;
        if (expect_rsp) begin
            e.vec = v; e.ext = x; e.tag = tag;
            exp_q.push_back(e);
        end
        @(negedge clk);
        iack_req = 1'b0;
        #1;
        if (!expect_rsp) chk(!ack_valid, tag, ack_valid, 0);
        @(negedge clk);
    endtask

    // monitor: compares each response against the queue
    always @(negedge clk) begin
        if (!rst && ack_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10 unexpected response actual=0x%0h expected=none", ack_vector);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(ack_vector == e.vec, {e.tag, " vector"}, ack_vector, e.vec);
                chk(ack_ext == e.ext, {e.tag, " ext"}, ack_ext, e.ext);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 14; a++) rd_chk(4'(a), 8'h00, "R1 reset read");
        lvl_chk(0, "R1 reset level");
        chk(!ack_valid, "R1 reset ack", ack_valid, 0);

        wr(4'd12, 8'h10);
        wr(4'd13, 8'h40);
        rd_chk(4'd13, 8'h40, "R9 base readback");

        // R2 layout, R3 edge, R6 level
        wr(4'd8, 8'h0D);
        rd_chk(4'd8, 8'h0D, "R2 ctrl readback");
        lvl_chk(0, "R6 no pending");
        pulse(8);
        lvl_chk(5, "R3 R6 timer level");
        rd_chk(4'd8, 8'h8D, "R2 pending bit");
        do_ack(3'd5, 1, 8'h48, 1'b0, "R9 timer ack");
        rd_chk(4'd8, 8'h8D, "R9 pending kept");

        // R6 higher level wins, R7 tie to lowest index
        wr(4'd1, 8'h0E);
        pulse(1);
        lvl_chk(6, "R6 higher level");
        do_ack(3'd6, 1, 8'h41, 1'b0, "R6 bus error ack");
        wr(4'd4, 8'h0E);
        pulse(4);
        do_ack(3'd6, 1, 8'h41, 1'b0, "R7 tie lowest");
        wr(4'd1, 8'h8E);
        rd_chk(4'd1, 8'h0E, "R4 w1c clears");
        do_ack(3'd6, 1, 8'h44, 1'b0, "R7 next winner");
        wr(4'd4, 8'h0E);
        rd_chk(4'd4, 8'h8E, "R4 zero keeps");

        // R10 mismatch
        do_ack(3'd3, 0, 8'h00, 1'b0, "R10 level mismatch");

        // R8 global enable
        wr(4'd12, 8'h00);
        lvl_chk(0, "R8 global off");
        do_ack(3'd6, 0, 8'h00, 1'b0, "R10 ack while idle");
        wr(4'd12, 8'h10);
        lvl_chk(6, "R8 global on");
        wr(4'd4, 8'h8E);
        wr(4'd8, 8'h8D);
        lvl_chk(0, "R4 all cleared");

        // R5 software source
        wr(4'd10, 8'h4B);
        rd_chk(4'd10, 8'h8B, "R5 soft pending");
        lvl_chk(3, "R5 soft level");
        do_ack(3'd3, 1, 8'h4A, 1'b0, "R5 soft vector");
        wr(4'd10, 8'h8B);
        lvl_chk(0, "R5 soft cleared");

        // R11 serial vector select
        wr(4'd3, 8'h0F);
        pulse(3);
        lvl_chk(7, "R11 serial level");
        do_ack(3'd7, 1, 8'h00, 1'b1, "R11 external");
        wr(4'd3, 8'h1F);
        rd_chk(4'd3, 8'h9F, "R11 select readback");
        do_ack(3'd7, 1, 8'h43, 1'b0, "R11 internal");
        wr(4'd3, 8'h9F);

        // R12 abort live state, R3 held line
        @(negedge clk);
        hw_irq[2] = 1'b1;
        @(negedge clk);
        rd_chk(4'd2, 8'hC0, "R12 live high");
        lvl_chk(0, "R6 disabled source");
        wr(4'd2, 8'h80);
        @(negedge clk);
        rd_chk(4'd2, 8'h40, "R3 held no repend");
        hw_irq[2] = 1'b0;
        @(negedge clk);
        rd_chk(4'd2, 8'h00, "R12 live low");

        // R13 edge and clear together
        @(negedge clk);
        hw_irq[0] = 1'b1; bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = 8'h80;
        @(negedge clk);
        bus_we = 1'b0; hw_irq[0] = 1'b0;
        rd_chk(4'd0, 8'h80, "R13 set wins");

        // R6 level zero never requests
        wr(4'd9, 8'h08);
        pulse(9);
        rd_chk(4'd9, 8'h88, "R6 level0 pending");
        lvl_chk(0, "R6 level0 idle");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R9 responses drained", exp_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule